// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches a set of external interrupt pins and turns their activity into interrupt requests for the rest of the chip. Each pin is first brought into the clock domain by a two-stage synchroniser. It is then classified by a per-line trigger type: a low or high level, a falling edge, a rising edge, or both edges. A qualifying event latches a sticky pending bit for that line. The pins are grouped into banks of eight, and every bank owns a control word, a mask word and a pending word on a simple word-addressed register bus.

The lower sixteen lines each drive a dedicated request toward a downstream vectored controller. The upper sixteen lines are merged into one shared request. Software services the shared request by reading a status word, which names the highest-numbered pending, unmasked line of that group. Software clears a pending line by writing a one to its pending bit.

Register map (word address on `bus_addr`): 0 to 3 are the control words of banks 0 to 3, 4 to 7 the mask words, 8 to 11 the pending words and 12 the status word. Line n lives in bank n/8 at position n mod 8. Reads of other addresses return zero, and writes to them are dropped.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every mask word reads 0xFF, every control word reads 0, `irq_direct` and `irq_shared` are low and the status word reads 0.
- R2: In a bank's control word, line n's trigger code sits in bits [(n mod 8)*4+2 : (n mod 8)*4]. Bit 3 of each nibble is not stored and reads 0, so writing 0xFFFFFFFF reads back 0x77777777.
- R3: Code 000 is level low and 001 is level high. While the level condition holds, the pending bit is set again on every clock, so a clear written during the condition leaves it set. The reset default of code 000 with pins low therefore sets every pending bit.
- R4: Code 011 is rising edge, 010 is falling edge and 100 is both edges. Codes 101, 110 and 111 never set pending.
- R5: A pin change applied between clock edges sets the pending bit on the third rising clock edge that follows, and not on the second.
- R6: A mask bit of 1 keeps the line off its request output while pending still records events. Only the low 8 bits of a mask word are stored, and the other bits read 0.
- R7: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. A pending bit only falls after such a clear.
- R8: When a clear and a new trigger event for the same line land on the same clock edge, the pending bit stays set.
- R9: For lines 0 to 15, `irq_direct[n]` is high exactly when line n is pending and unmasked.
- R10: `irq_shared` is high exactly when any of lines 16 to 31 is pending and unmasked.
- R11: The status word (address 12) has bit 8 as a valid flag and bits 4:0 as the highest-numbered pending, unmasked line among 16 to 31. It reads 0 when none is pending and unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 32 | External interrupt pins, asynchronous |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_direct | output | 16 | Per-line requests for lines 0 to 15 |
| irq_shared | output | 1 | Combined request for lines 16 to 31 |

## Verification
The assertions take for granted that a bus write lasts one cycle and that the pins are steady at reset release. The edge detector's history starts at zero, so a pin already high would look like a rising edge. The stimulus drives every pin low through reset and changes bus signals and pins only at falling clock edges. It holds a pin for at least four cycles before it reprograms or clears that line, so every event the assertions relate to a clear or a set has passed through the synchroniser.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int TYPE_W = 3;

    typedef enum logic [TYPE_W-1:0] {
        TRIG_LVL_LO = 3'b000,
        TRIG_LVL_HI = 3'b001,
        TRIG_FALL   = 3'b010,
        TRIG_RISE   = 3'b011,
        TRIG_BOTH   = 3'b100
    } trig_e;

    // Event for one line given its trigger code, current and previous level.
    function automatic logic trig_hit(input logic [TYPE_W-1:0] code,
                                      input logic now_lvl,
                                      input logic old_lvl);
        logic hit;
        case (code)
            TRIG_LVL_LO: hit = !now_lvl;
            TRIG_LVL_HI: hit = now_lvl;
            TRIG_FALL:   hit = !now_lvl && old_lvl;
            TRIG_RISE:   hit = now_lvl && !old_lvl;
            TRIG_BOTH:   hit = now_lvl != old_lvl;
            default:     hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
    import ext_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [W-1:0]            lvl,
    input  logic [W-1:0][TYPE_W-1:0] mode,
    output logic [W-1:0]            evt
);
    logic [W-1:0] prev_d, prev_q;

    always_comb prev_d = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar g = 0; g < W; g++) begin : g_line
        assign evt[g] = trig_hit(mode[g], lvl[g], prev_q[g]);

        // R4: a rising-edge event needs the level to have been low one clock earlier
        p_rise_needs_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[g] && mode[g] == TRIG_RISE) |-> (lvl[g] && !$past(lvl[g])));

        // R4: codes above both-edges never raise an event
        p_spare_codes_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[g] > TRIG_BOTH) |-> !evt[g]);
    end

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int NUM_BANKS    = 4,
    parameter int BANK_LINES   = 8,
    parameter int DIRECT_LINES = 16,
    parameter int ADDR_W       = 4,
    parameter int DATA_W       = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [31:0]             ext_pin,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic [DIRECT_LINES-1:0] irq_direct,
    output logic                    irq_shared
);
    localparam int NUM_LINES    = NUM_BANKS * BANK_LINES;
    localparam int SHARED_LINES = NUM_LINES - DIRECT_LINES;
    localparam int FIELD_W      = 4;
    localparam int IDX_W        = $clog2(NUM_LINES);
    localparam int BANK_W       = $clog2(NUM_BANKS);
    localparam int RGN_W        = ADDR_W - BANK_W;
    localparam int VLD_BIT      = 8;
    localparam logic [RGN_W-1:0] RGN_CTRL = RGN_W'(0);
    localparam logic [RGN_W-1:0] RGN_MASK = RGN_W'(1);
    localparam logic [RGN_W-1:0] RGN_PEND = RGN_W'(2);
    localparam logic [RGN_W-1:0] RGN_STAT = RGN_W'(3);

    typedef struct packed {
        logic [NUM_LINES-1:0][TYPE_W-1:0] ctrl;
        logic [NUM_LINES-1:0]             mask;
        logic [NUM_LINES-1:0]             pend;
    } regs_t;

    regs_t st_d, st_q;

    logic [NUM_LINES-1:0] pin_sync, evt, clr, live;
    logic [RGN_W-1:0]     rgn;
    logic [BANK_W-1:0]    bank;
    logic [IDX_W-1:0]     stat_idx;
    logic                 stat_vld;
    logic                 wdata_unused;

    assign wdata_unused = ^bus_wdata;
    assign rgn  = bus_addr[ADDR_W-1:BANK_W];
    assign bank = bus_addr[BANK_W-1:0];

    ext_irq_sync #(.W(NUM_LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_pin[NUM_LINES-1:0]),
        .sync_out (pin_sync)
    );

    ext_irq_detect #(.W(NUM_LINES)) u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (pin_sync),
        .mode  (st_q.ctrl),
        .evt   (evt)
    );

    // Next-state: register writes, write-1 clear, event set (set wins).
    always_comb begin
        int base;
        st_d = st_q;
        clr  = '0;
        base = int'(bank) * BANK_LINES;
        if (bus_wr) begin
            if (rgn == RGN_CTRL) begin
                for (int l = 0; l < BANK_LINES; l++)
                    st_d.ctrl[base + l] = bus_wdata[l*FIELD_W +: TYPE_W];
            end else if (rgn == RGN_MASK) begin
                st_d.mask[base +: BANK_LINES] = bus_wdata[BANK_LINES-1:0];
            end else if (rgn == RGN_PEND) begin
                clr[base +: BANK_LINES] = bus_wdata[BANK_LINES-1:0];
            end
        end
        st_d.pend = (st_q.pend & ~clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= '0;
            st_q.mask <= '1;
            st_q.pend <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign live       = st_q.pend & ~st_q.mask;
    assign irq_direct = live[DIRECT_LINES-1:0];
    assign irq_shared = |live[NUM_LINES-1:DIRECT_LINES];

    // Highest-numbered live line of the shared group: later hits override.
    always_comb begin
        stat_idx = '0;
        stat_vld = 1'b0;
        for (int i = DIRECT_LINES; i < NUM_LINES; i++) begin
            if (live[i]) begin
                stat_idx = IDX_W'(i);
                stat_vld = 1'b1;
            end
        end
    end

    // Read mux.
    always_comb begin
        int base;
        bus_rdata = '0;
        base = int'(bank) * BANK_LINES;
        if (rgn == RGN_CTRL) begin
            for (int l = 0; l < BANK_LINES; l++)
                bus_rdata[l*FIELD_W +: FIELD_W] = {1'b0, st_q.ctrl[base + l]};
        end else if (rgn == RGN_MASK) begin
            bus_rdata[BANK_LINES-1:0] = st_q.mask[base +: BANK_LINES];
        end else if (rgn == RGN_PEND) begin
            bus_rdata[BANK_LINES-1:0] = st_q.pend[base +: BANK_LINES];
        end else if (rgn == RGN_STAT && bank == '0) begin
            bus_rdata[VLD_BIT]     = stat_vld;
            bus_rdata[IDX_W-1:0]   = stat_idx;
        end
    end

    // R7: a pending bit only falls after a write-1 clear on the previous edge
    p_fall_needs_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.pend) & ~st_q.pend & ~$past(clr)) == '0);

    // R8: every event sets its pending bit, even when a clear coincides
    p_event_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((st_q.pend & $past(evt)) == $past(evt)));

    // R10, R11: shared request and status valid flag agree
    p_shared_matches_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_shared == stat_vld);

    // R11: the reported index is a live line of the shared group
    p_status_index_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |-> (int'(stat_idx) >= DIRECT_LINES && live[stat_idx]));

    initial begin
        a_shared_count_r10: assert (SHARED_LINES > 0 && FIELD_W * BANK_LINES <= DATA_W);
    end

endmodule

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ext_pin = '0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_direct;
    logic        irq_shared;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ext_irq_ctrl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_pin    (ext_pin),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_direct (irq_direct),
        .irq_shared (irq_shared)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Check pending bit of line, outputs and status against an expected live state.
    task automatic chk_line(input int ln, input bit exp_pend, input bit exp_live, input string req);
        logic [31:0] v;
        logic [31:0] st_exp;
        rd(4'(8 + ln / 8), v);
        chk(v[ln % 8] == exp_pend, req, v, {24'd0, 8'(exp_pend) << (ln % 8)});
        chk(irq_direct == ((ln < 16 && exp_live) ? 16'(1 << ln) : 16'd0), (ln < 16) ? "R9" : "R9 quiet",
            {16'd0, irq_direct}, (ln < 16 && exp_live) ? (32'd1 << ln) : 32'd0);
        chk(irq_shared == (ln >= 16 && exp_live), "R10", {31'd0, irq_shared}, {31'd0, ln >= 16 && exp_live});
        st_exp = (ln >= 16 && exp_live) ? (32'h100 | 32'(ln)) : 32'd0;
        rd(4'd12, v);
        chk(v == st_exp, "R11", v, st_exp);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        wait_neg(5);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int b = 0; b < 4; b++) begin
            rd(4'(4 + b), v); chk(v == 32'hFF, "R1 mask", v, 32'hFF);
            rd(4'(b), v);     chk(v == 32'h0, "R1 ctrl", v, 32'h0);
        end
        chk(irq_direct == 16'd0 && !irq_shared, "R1 outputs", {15'd0, irq_shared, irq_direct}, 32'd0);
        rd(4'd12, v); chk(v == 32'd0, "R1 status", v, 32'd0);

        // R3: default level-low with pins low sets every pending bit
        wait_neg(4);
        for (int b = 0; b < 4; b++) begin
            rd(4'(8 + b), v); chk(v == 32'hFF, "R3 default level low", v, 32'hFF);
        end

        // R2 control layout, then disable every line
        for (int b = 0; b < 4; b++) begin
            wr(4'(b), 32'hFFFFFFFF);
            rd(4'(b), v); chk(v == 32'h77777777, "R2 readback", v, 32'h77777777);
            wr(4'(b), 32'h12340567);
            rd(4'(b), v); chk(v == 32'h12340567, "R2 fields", v, 32'h12340567);
            wr(4'(b), 32'h77777777);
        end
        for (int b = 0; b < 4; b++) wr(4'(8 + b), 32'hFF);
        wait_neg(4);
        for (int b = 0; b < 4; b++) begin
            rd(4'(8 + b), v); chk(v == 32'd0, "R7 clear all", v, 32'd0);
        end

        // R6 mask word keeps only low 8 bits
        wr(4'd5, 32'hFFFFFF00);
        rd(4'd5, v); chk(v == 32'h0, "R6 mask width", v, 32'h0);
        wr(4'd5, 32'hFF);

        // Sweep every line through every trigger code plus a spare code
        for (int ln = 0; ln < 32; ln++) begin
            for (int code = 0; code < 6; code++) begin
                automatic int  b = ln / 8;
                automatic int  j = ln % 8;
                automatic bit  idle = (code == 0 || code == 2);
                automatic bit  fires = (code <= 4);
                automatic bit  lvl = (code <= 1);
                automatic logic [31:0] cv = (32'h77777777 & ~(32'hF << (j * 4))) | (32'(code) << (j * 4));
                automatic bit  keep;

                @(negedge clk); ext_pin[ln] = idle;
                wait_neg(4);
                wr(4'(b), cv);
                wr(4'(8 + b), 32'hFF);
                wr(4'(4 + b), 32'(8'hFF & ~(8'd1 << j)));
                chk_line(ln, 1'b0, 1'b0, "R4 idle");

                // R5 latency: pending not yet after two edges, set after the third
                @(negedge clk); ext_pin[ln] = ~idle;
                @(posedge clk); @(posedge clk); @(negedge clk);
                rd(4'(8 + b), v); chk(v[j] == 1'b0, "R5 early", v, 32'd0);
                @(negedge clk);
                chk_line(ln, fires, fires, (code == 5) ? "R4 spare code" : "R4 R5 fire");

                // R3: clear during a held level is overridden
                wr(4'(8 + b), 32'(8'd1 << j));
                rd(4'(8 + b), v); chk(v[j] == lvl, "R3 level reassert", v, {31'd0, lvl});

                // Return pin: only both-edges fires again; level keeps sticky bit
                @(negedge clk); ext_pin[ln] = idle;
                wait_neg(4);
                keep = (code == 0 || code == 1 || code == 4);
                chk_line(ln, keep, keep, "R4 second edge");

                // R6: mask hides output but pending stays
                wr(4'(4 + b), 32'hFF);
                chk_line(ln, keep, 1'b0, "R6 masked");

                wr(4'(b), 32'h77777777);
                @(negedge clk); ext_pin[ln] = 1'b0;
                wait_neg(4);
                wr(4'(8 + b), 32'hFF);
            end
        end

        // R8: clear landing on the same edge as a new both-edges event
        wr(4'd0, 32'h74777777);          // line 6 both edges
        wr(4'd4, 32'hBF);
        @(negedge clk); ext_pin[6] = 1'b1;
        wait_neg(4);
        rd(4'd8, v); chk(v[6] == 1'b1, "R8 setup", v, 32'h40);
        @(negedge clk); ext_pin[6] = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); bus_addr = 4'd8; bus_wdata = 32'h40; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        rd(4'd8, v); chk(v[6] == 1'b1, "R8 set wins", v, 32'h40);
        wait_neg(3);
        wr(4'd8, 32'h40);
        rd(4'd8, v); chk(v[6] == 1'b0, "R7 clear", v, 32'h0);

        // R7: writing zero leaves pending untouched
        @(negedge clk); ext_pin[6] = 1'b1;
        wait_neg(4);
        wr(4'd8, 32'h00);
        rd(4'd8, v); chk(v[6] == 1'b1, "R7 write zero", v, 32'h40);
        chk(irq_direct == 16'h0040, "R9 line 6", {16'd0, irq_direct}, 32'h40);
        wr(4'd0, 32'h77777777);
        @(negedge clk); ext_pin[6] = 1'b0;
        wait_neg(4);
        wr(4'd8, 32'hFF);
        wr(4'd4, 32'hFF);

        // R11: two shared lines live, priority to the higher index
        wr(4'd2, 32'h77777177);           // line 18 level high
        wr(4'd3, 32'h71777777);           // line 30 level high
        wr(4'd6, 32'hFB);
        wr(4'd7, 32'hBF);
        @(negedge clk); ext_pin[18] = 1'b1; ext_pin[30] = 1'b1;
        wait_neg(4);
        rd(4'd12, v); chk(v == 32'h11E, "R11 highest", v, 32'h11E);
        chk(irq_shared == 1'b1, "R10 any", {31'd0, irq_shared}, 32'd1);
        wr(4'd7, 32'hFF);
        rd(4'd12, v); chk(v == 32'h112, "R11 next lower", v, 32'h112);
        wr(4'd6, 32'hFF);
        rd(4'd12, v); chk(v == 32'h0, "R11 none", v, 32'h0);
        chk(irq_shared == 1'b0, "R10 none", {31'd0, irq_shared}, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule